// File: doc/BRIEF.md
# Debug Emulator Mode Controller

This block sits beside a processor core and decides when the core runs in emulator mode, the privileged debug state in which a debug handler saves context without being disturbed. Three events can move the core into the mode: a force-entry control bit that is looked at when reset exception processing starts, a debug interrupt raised by the breakpoint logic, and a trace-force control bit looked at when trace exception processing starts. The only way out is the strobe that marks completion of a return-from-exception.

While the mode is active the block replaces the core's 4-bit processor status with a fixed entry code and later a fixed exit code. It blocks every interrupt request level, including the non-maskable level 7, and supplies vector number 12 for debug interrupts. When address remapping is enabled it forces every bus access into a dedicated address space and turns off the cache and local SRAM enables. The core, the breakpoint comparators and the serial debug command port are outside the block. They appear only as input strobes and levels.

The controller is a four-state machine. ST_NORMAL is ordinary execution. ST_ENTRY holds the entry status code for a fixed number of cycles. ST_EMU is the body of emulator mode. ST_EXIT is a single cycle that shows the exit code. The transitions are:
- enter: ST_NORMAL to ST_ENTRY on any accepted entry event.
- hold_done: ST_ENTRY to ST_EMU when the hold counter expires.
- rte: ST_EMU to ST_EXIT on the return strobe.
- settle: ST_EXIT to ST_NORMAL when nothing is pending.
- re_enter: ST_EXIT to ST_ENTRY when a debug request is pending or another entry event is accepted.

Top module: `emu_mode_ctrl`

## Requirements
- R1: After reset, emu_mode_o is 0 and pst_o equals core_pst_i.
- R2: force_wr_i loads force_data_i into the force-entry bit only while halted_i is 1. At other times the write has no effect. While the bit is 1, a reset_start_i pulse enters the mode. Any entry clears the bit, so a later reset_start_i pulse does not enter again.
- R3: A dbg_req_i pulse is latched. It is taken only at a cycle where int_sample_i is 1. In the first cycle of that entry, vec_valid_o is 1 for one cycle and vec_num_o is 12. Entries from reset or trace leave vec_valid_o at 0.
- R4: A trace_start_i pulse enters the mode only when trace_en_i is 1.
- R5: From the first cycle of the mode, pst_o is 0xD for exactly 3 cycles. After that it returns to core_pst_i.
- R6: The mode ends only when rte_done_i is seen in ST_EMU. For one cycle after that, pst_o is 0x7 and emu_mode_o is 0. An rte_done_i pulse in ST_NORMAL has no effect.
- R7: Outside the entry and exit cycles, pst_o equals core_pst_i.
- R8: While emu_mode_o is 1, irq_level_o is 0 for every irq_level_i, including 7. Otherwise irq_level_i passes through unchanged.
- R9: While emu_mode_o and remap_en_i are both 1:
  - bus_tt_o is 0x2.
  - bus_tm_o is 0x5 for reads (bus_wr_i=0) and 0x6 for writes.
  - cache_en_o and sram_en_o are 0.
  Otherwise bus_tt_i, bus_tm_i, cache_en_i and sram_en_i pass through unchanged.
- R10: A debug request that arrives during the mode stays pending. In the cycle after the ST_EXIT cycle, the block enters the mode again without waiting for int_sample_i, and vec_valid_o is 1.
- R11: A reset_start_i or trace_start_i event during the mode has no effect on pst_o or emu_mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halted_i | input | 1 | Core is halted before reset processing |
| force_wr_i | input | 1 | Write strobe for the force-entry bit |
| force_data_i | input | 1 | Value written to the force-entry bit |
| reset_start_i | input | 1 | Reset exception processing begins |
| dbg_req_i | input | 1 | Debug interrupt request from the breakpoint logic |
| int_sample_i | input | 1 | Core interrupt sampling point |
| trace_en_i | input | 1 | Trace-force control bit |
| trace_start_i | input | 1 | Trace exception processing begins |
| rte_done_i | input | 1 | Return-from-exception has completed |
| remap_en_i | input | 1 | Address remap enable |
| core_pst_i | input | 4 | Core's normal processor status |
| irq_level_i | input | 3 | Incoming interrupt priority level |
| bus_tt_i | input | 2 | Core transfer type |
| bus_tm_i | input | 3 | Core transfer modifier |
| bus_wr_i | input | 1 | Current access is a write |
| cache_en_i | input | 1 | Core cache enable |
| sram_en_i | input | 1 | Core local SRAM enable |
| emu_mode_o | output | 1 | Core is in emulator mode |
| pst_o | output | 4 | Processor status seen outside the block |
| irq_level_o | output | 3 | Interrupt level after masking |
| vec_valid_o | output | 1 | Debug vector is being supplied |
| vec_num_o | output | 8 | Exception vector number |
| bus_tt_o | output | 2 | Transfer type after override |
| bus_tm_o | output | 3 | Transfer modifier after override |
| cache_en_o | output | 1 | Cache enable after override |
| sram_en_o | output | 1 | SRAM enable after override |

## Verification
The bench targets four mistakes:
- A force-entry bit that accepts writes while the core runs, or that survives entry, would send a second reset into the mode by mistake.
- A debug request that is taken before a sampling point, or lost because it arrived during the mode, would show up as a wrong or missing pst_o of 0xD and a missing vector strobe after the exit code.
- An off-by-one in the entry hold would show 0xD for two or four cycles.
- A mask that forgets level 7, or a remap that ignores the access direction, would leak a raw interrupt level or the wrong transfer modifier.

// File: rtl/emu_pkg.sv
package emu_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_EMU    = 2'd2,
        ST_EXIT   = 2'd3
    } emu_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RESET = 2'd1,
        CAUSE_DEBUG = 2'd2,
        CAUSE_TRACE = 2'd3
    } emu_cause_e;
endpackage

// File: rtl/emu_entry_detect.sv
module emu_entry_detect
    import emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  emu_state_e state_i,
    input  logic       halted_i,
    input  logic       force_wr_i,
    input  logic       force_data_i,
    input  logic       reset_start_i,
    input  logic       dbg_req_i,
    input  logic       int_sample_i,
    input  logic       trace_en_i,
    input  logic       trace_start_i,
    output logic       enter_o,
    output emu_cause_e cause_o
);
    logic force_q;
    logic dbg_pend_q;
    logic open_win;
    logic dbg_any;
    logic take_reset, take_dbg, take_trace;

    assign open_win   = (state_i == ST_NORMAL) || (state_i == ST_EXIT);
    assign dbg_any    = dbg_pend_q || dbg_req_i;
    assign take_reset = open_win && reset_start_i && force_q;
    assign take_dbg   = open_win && dbg_any && (int_sample_i || (state_i == ST_EXIT));
    assign take_trace = open_win && trace_start_i && trace_en_i;
    assign enter_o    = take_reset || take_dbg || take_trace;

    always_comb begin
        if (take_reset)      cause_o = CAUSE_RESET;
        else if (take_dbg)   cause_o = CAUSE_DEBUG;
        else if (take_trace) cause_o = CAUSE_TRACE;
        else                 cause_o = CAUSE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_q    <= 1'b0;
            dbg_pend_q <= 1'b0;
        end else begin
            if (enter_o)                     force_q <= 1'b0;
            else if (halted_i && force_wr_i) force_q <= force_data_i;
            dbg_pend_q <= dbg_any && !(enter_o && cause_o == CAUSE_DEBUG);
        end
    end

    // R2
    force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |=> !force_q);

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_i && state_i == ST_EMU) |=> dbg_pend_q);
endmodule

// File: rtl/emu_fsm.sv
module emu_fsm
    import emu_pkg::*;
#(
    parameter int ENTRY_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_i,
    input  emu_cause_e cause_i,
    input  logic       rte_done_i,
    output emu_state_e state_o,
    output logic       in_emu_o,
    output logic       entry_o,
    output logic       exit_o,
    output logic       vec_valid_o
);
    localparam int CNT_W = $clog2(ENTRY_HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_HOLD - 1);

    emu_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    emu_cause_e       cause_q, cause_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_NORMAL, ST_EXIT: begin
                if (enter_i) begin
                    state_d = ST_ENTRY;
                    cnt_d   = '0;
                    cause_d = cause_i;
                end else begin
                    state_d = ST_NORMAL;
                end
            end
            ST_ENTRY: begin
                if (cnt_q == CNT_LAST) state_d = ST_EMU;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            ST_EMU: begin
                if (rte_done_i) begin
                    state_d = ST_EXIT;
                    cause_d = CAUSE_NONE;
                end
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            cnt_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        state_o     = state_q;
        in_emu_o    = 1'b0;
        entry_o     = 1'b0;
        exit_o      = 1'b0;
        vec_valid_o = 1'b0;
        unique case (state_q)
            ST_NORMAL: ;
            ST_ENTRY: begin
                in_emu_o    = 1'b1;
                entry_o     = 1'b1;
                vec_valid_o = (cnt_q == '0) && (cause_q == CAUSE_DEBUG);
            end
            ST_EMU:  in_emu_o = 1'b1;
            ST_EXIT: exit_o   = 1'b1;
            default: ;
        endcase
    end

    // R6
    rte_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMU && rte_done_i) |=> (state_q == ST_EXIT));

    // R5
    entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTRY && cnt_q == CNT_LAST) |=> (state_q == ST_EMU));
endmodule

// File: rtl/emu_out_stage.sv
module emu_out_stage #(
    parameter int          PST_W      = 4,
    parameter logic [3:0]  PST_ENTRY  = 4'hD,
    parameter logic [3:0]  PST_EXIT   = 4'h7,
    parameter logic [1:0]  REMAP_TT   = 2'h2,
    parameter logic [2:0]  REMAP_TM_R = 3'h5,
    parameter logic [2:0]  REMAP_TM_W = 3'h6
) (
    input  logic             in_emu_i,
    input  logic             entry_i,
    input  logic             exit_i,
    input  logic             remap_en_i,
    input  logic [PST_W-1:0] core_pst_i,
    input  logic [2:0]       irq_level_i,
    input  logic [1:0]       bus_tt_i,
    input  logic [2:0]       bus_tm_i,
    input  logic             bus_wr_i,
    input  logic             cache_en_i,
    input  logic             sram_en_i,
    output logic [PST_W-1:0] pst_o,
    output logic [2:0]       irq_level_o,
    output logic [1:0]       bus_tt_o,
    output logic [2:0]       bus_tm_o,
    output logic             cache_en_o,
    output logic             sram_en_o
);
    logic remap_act;
    assign remap_act = in_emu_i && remap_en_i;

    always_comb begin
        if (entry_i)     pst_o = PST_W'(PST_ENTRY);
        else if (exit_i) pst_o = PST_W'(PST_EXIT);
        else             pst_o = core_pst_i;
    end

    assign irq_level_o = in_emu_i ? 3'd0 : irq_level_i;

    always_comb begin
        if (remap_act) begin
            bus_tt_o   = REMAP_TT;
            bus_tm_o   = bus_wr_i ? REMAP_TM_W : REMAP_TM_R;
            cache_en_o = 1'b0;
            sram_en_o  = 1'b0;
        end else begin
            bus_tt_o   = bus_tt_i;
            bus_tm_o   = bus_tm_i;
            cache_en_o = cache_en_i;
            sram_en_o  = sram_en_i;
        end
    end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
    import emu_pkg::*;
#(
    parameter int          ENTRY_HOLD = 3,
    parameter int          VEC_W      = 8,
    parameter int          DBG_VEC    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted_i,
    input  logic             force_wr_i,
    input  logic             force_data_i,
    input  logic             reset_start_i,
    input  logic             dbg_req_i,
    input  logic             int_sample_i,
    input  logic             trace_en_i,
    input  logic             trace_start_i,
    input  logic             rte_done_i,
    input  logic             remap_en_i,
    input  logic [3:0]       core_pst_i,
    input  logic [2:0]       irq_level_i,
    input  logic [1:0]       bus_tt_i,
    input  logic [2:0]       bus_tm_i,
    input  logic             bus_wr_i,
    input  logic             cache_en_i,
    input  logic             sram_en_i,
    output logic             emu_mode_o,
    output logic [3:0]       pst_o,
    output logic [2:0]       irq_level_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_num_o,
    output logic [1:0]       bus_tt_o,
    output logic [2:0]       bus_tm_o,
    output logic             cache_en_o,
    output logic             sram_en_o
);
    emu_state_e state;
    emu_cause_e cause;
    logic       enter, entry, exit_c;

    emu_entry_detect u_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .halted_i      (halted_i),
        .force_wr_i    (force_wr_i),
        .force_data_i  (force_data_i),
        .reset_start_i (reset_start_i),
        .dbg_req_i     (dbg_req_i),
        .int_sample_i  (int_sample_i),
        .trace_en_i    (trace_en_i),
        .trace_start_i (trace_start_i),
        .enter_o       (enter),
        .cause_o       (cause)
    );

    emu_fsm #(.ENTRY_HOLD(ENTRY_HOLD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (enter),
        .cause_i     (cause),
        .rte_done_i  (rte_done_i),
        .state_o     (state),
        .in_emu_o    (emu_mode_o),
        .entry_o     (entry),
        .exit_o      (exit_c),
        .vec_valid_o (vec_valid_o)
    );

    assign vec_num_o = VEC_W'(DBG_VEC);

    emu_out_stage u_out (
        .in_emu_i    (emu_mode_o),
        .entry_i     (entry),
        .exit_i      (exit_c),
        .remap_en_i  (remap_en_i),
        .core_pst_i  (core_pst_i),
        .irq_level_i (irq_level_i),
        .bus_tt_i    (bus_tt_i),
        .bus_tm_i    (bus_tm_i),
        .bus_wr_i    (bus_wr_i),
        .cache_en_i  (cache_en_i),
        .sram_en_i   (sram_en_i),
        .pst_o       (pst_o),
        .irq_level_o (irq_level_o),
        .bus_tt_o    (bus_tt_o),
        .bus_tm_o    (bus_tm_o),
        .cache_en_o  (cache_en_o),
        .sram_en_o   (sram_en_o)
    );

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode_o |-> (irq_level_o == 3'd0));

    // R5
    entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emu_mode_o) |-> (pst_o == 4'hD));

    // R6
    leave_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(emu_mode_o) |-> $past(rte_done_i));

    // R3
    vec_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (emu_mode_o && vec_num_o == VEC_W'(12)));

    // R9
    remap_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_mode_o && remap_en_i) |-> (bus_tt_o == 2'h2 && !cache_en_o && !sram_en_o));
endmodule

// File: tb/emu_mode_ctrl_tb.sv
module emu_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halted_i = 0, force_wr_i = 0, force_data_i = 0, reset_start_i = 0;
    logic dbg_req_i = 0, int_sample_i = 0, trace_en_i = 0, trace_start_i = 0;
    logic rte_done_i = 0, remap_en_i = 0, bus_wr_i = 0, cache_en_i = 1, sram_en_i = 1;
    logic [3:0] core_pst_i = 4'h3;
    logic [2:0] irq_level_i = 3'd0;
    logic [1:0] bus_tt_i = 2'h0;
    logic [2:0] bus_tm_i = 3'h1;
    logic       emu_mode_o, vec_valid_o, cache_en_o, sram_en_o;
    logic [3:0] pst_o;
    logic [2:0] irq_level_o, bus_tm_o;
    logic [7:0] vec_num_o;
    logic [1:0] bus_tt_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    emu_mode_ctrl dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Called one negedge after the entry pulse was applied (pulse already cleared).
    task automatic check_entry(input string req, input bit dbg);
        chk({req, " R5 pst hold 1"}, pst_o, 4'hD);
        chk({req, " emu_mode"}, emu_mode_o, 1);
        chk({req, " R3 vec_valid"}, vec_valid_o, dbg);
        if (dbg) chk({req, " R3 vec_num"}, vec_num_o, 12);
        step();
        chk({req, " R5 pst hold 2"}, pst_o, 4'hD);
        chk({req, " R3 vec_valid one cycle"}, vec_valid_o, 0);
        step();
        chk({req, " R5 pst hold 3"}, pst_o, 4'hD);
        step();
        chk({req, " R5 R7 pst after hold"}, pst_o, core_pst_i);
        chk({req, " still emu"}, emu_mode_o, 1);
    endtask

    task automatic do_rte(input string req);
        rte_done_i = 1;
        step();
        rte_done_i = 0;
        chk({req, " R6 exit pst"}, pst_o, 4'h7);
        chk({req, " R6 exit mode"}, emu_mode_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 mode after reset", emu_mode_o, 0);
        chk("R1 pst passthrough", pst_o, 4'h3);
        rte_done_i = 1;
        step();
        rte_done_i = 0;
        chk("R6 rte in normal ignored", pst_o, 4'h3);
        chk("R6 rte in normal mode", emu_mode_o, 0);
    endtask

    task automatic t_force();
        halted_i = 0; force_wr_i = 1; force_data_i = 1;
        step();
        force_wr_i = 0;
        reset_start_i = 1;
        step();
        reset_start_i = 0;
        chk("R2 write while running ignored", emu_mode_o, 0);
        halted_i = 1; force_wr_i = 1; force_data_i = 1;
        step();
        force_wr_i = 0; halted_i = 0;
        reset_start_i = 1;
        step();
        reset_start_i = 0;
        check_entry("R2 force entry", 0);
        step();
        do_rte("R2");
        step();
        chk("R7 pst normal after exit", pst_o, 4'h3);
        reset_start_i = 1;
        step();
        reset_start_i = 0;
        chk("R2 bit cleared after entry", emu_mode_o, 0);
    endtask

    task automatic t_debug();
        irq_level_i = 3'd7;
        dbg_req_i = 1;
        step();
        dbg_req_i = 0;
        step();
        step();
        chk("R3 not taken before sample point", emu_mode_o, 0);
        chk("R8 irq passthrough in normal", irq_level_o, 7);
        int_sample_i = 1;
        step();
        int_sample_i = 0;
        check_entry("R3 debug entry", 1);
        chk("R8 level 7 masked", irq_level_o, 0);
        trace_en_i = 1; trace_start_i = 1; reset_start_i = 1;
        step();
        trace_start_i = 0; reset_start_i = 0; trace_en_i = 0;
        chk("R11 trace during emu ignored", pst_o, 4'h3);
        chk("R11 mode unchanged", emu_mode_o, 1);
        dbg_req_i = 1;
        step();
        dbg_req_i = 0;
        step();
        do_rte("R10");
        step();
        check_entry("R10 pending re-entry", 1);
        do_rte("R10 second");
        step();
        chk("R10 back to normal", emu_mode_o, 0);
        chk("R8 irq restored", irq_level_o, 7);
        irq_level_i = 3'd0;
    endtask

    task automatic t_trace();
        trace_en_i = 0; trace_start_i = 1;
        step();
        trace_start_i = 0;
        chk("R4 trace without enable", emu_mode_o, 0);
        trace_en_i = 1; trace_start_i = 1;
        step();
        trace_start_i = 0; trace_en_i = 0;
        check_entry("R4 trace entry", 0);
    endtask

    task automatic t_bus();
        core_pst_i = 4'h5;
        remap_en_i = 1; bus_wr_i = 0; bus_tt_i = 2'h1; bus_tm_i = 3'h2;
        step();
        chk("R7 pst follows core", pst_o, 4'h5);
        chk("R9 read tt", bus_tt_o, 2);
        chk("R9 read tm", bus_tm_o, 5);
        chk("R9 cache off", cache_en_o, 0);
        chk("R9 sram off", sram_en_o, 0);
        bus_wr_i = 1;
        step();
        chk("R9 write tm", bus_tm_o, 6);
        remap_en_i = 0;
        step();
        chk("R9 remap off tt", bus_tt_o, 1);
        chk("R9 remap off tm", bus_tm_o, 2);
        chk("R9 remap off cache", cache_en_o, 1);
        remap_en_i = 1;
        do_rte("R9");
        chk("R9 normal passthrough tt", bus_tt_o, 1);
        chk("R9 normal passthrough sram", sram_en_o, 1);
        remap_en_i = 0;
        core_pst_i = 4'h3;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_force();
        t_debug();
        t_trace();
        t_bus();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule